// File: doc/BRIEF.md
# Execute-Stage Step Sequencer with Load Fill Tracking

This block is the control core of an execution stage. It takes one micro-operation at a time over a valid/ready input. A micro-operation is a short list of steps. Each step names an operation class, an optional predicate register with the bit value it expects, two source registers, an optional destination register, an address and a size code. The stage works through the steps in order, at most one step per clock. It reads operands from a small register file that keeps one valid bit per register. Another unit in the pipeline can fill registers through a write port.

A load has at most one memory request in flight. The stage raises a single fill request that carries the address and size, then waits. It completes the load when one of the parallel response lanes returns data tagged with the same address. Responses are held for one cycle only: whatever the stage does not match in that cycle is lost. A store step sends out an address, data and size record.

Top module: `exec_fill_tracker`

## Requirements
- R1: `in_ready` is high exactly when no micro-operation is in progress. A micro-operation is taken on a clock where both `in_valid` and `in_ready` are high, and `in_valid` has no effect while the stage is busy. Step k of `in_steps` occupies bits k*SW upward, where SW is the width of the package step type. Counts above STEPS are clamped to STEPS.
- R2: A step whose predicate is enabled but whose predicate register is not valid stalls. No step advances, and no request or store is produced until that register becomes valid.
- R3: A step whose predicate register is valid but whose bit 0 differs from the expected bit is skipped. It writes no register, sends no fill request and sends no store.
- R4: A step whose source registers are not all valid stalls. A source value is captured the first cycle that register is valid, and that captured value is used even if the register is rewritten before the step completes.
- R5: A load step with no request outstanding raises `freq_valid` for exactly one cycle, the cycle after the decision, with the step's address and size code. It sends no further request while that load is outstanding.
- R6: While a load is outstanding, a valid response lane whose address equals the load address completes the load, and the lane data is written to the destination. When several lanes match, the lowest-numbered lane wins.
- R7: While a load is outstanding and no valid lane matches, the stage stalls for that cycle.
- R8: Responses live for one cycle only. A matching response that arrives before the request is outstanding is discarded, and the load waits for a later response.
- R9: Operation codes are 0 add (needs sources a and b, result a+b), 1 load (no sources, result is fill data), 2 store (needs a, result a) and 3 move (needs a, result a). When its destination is enabled, an evaluated step writes its result. A store raises `st_valid` for one cycle, the cycle after evaluation, with the step address, the value of source a and the size code.
- R10: When a step completes or is skipped, its captured operands and outstanding-request state are cleared. The next load therefore sends a fresh request, even to the same address.
- R11: After reset every register is not valid, the stage is idle, and no request or store is presented.
- R12: A write on the register write port sets that register's value and valid bit from the next cycle on. A micro-operation with a step count of 0 is accepted and leaves the stage idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Micro-operation offered |
| in_ready | output | 1 | Stage idle, can take a micro-operation |
| in_count | input | CW | Number of steps in the micro-operation |
| in_steps | input | STEPS*SW | Packed steps, step k at bits k*SW |
| wr_en | input | 1 | Register write from elsewhere in the pipeline |
| wr_idx | input | RW | Register index for that write |
| wr_data | input | DW | Value for that write |
| freq_valid | output | 1 | Fill request pulse |
| freq_addr | output | AW | Fill request address |
| freq_size | output | 2 | Fill request size code |
| frsp_valid | input | LANES | Per-lane response valid |
| frsp_addr | input | LANES*AW | Per-lane response address |
| frsp_data | input | LANES*DW | Per-lane response data |
| st_valid | output | 1 | Store record pulse |
| st_addr | output | AW | Store address |
| st_data | output | DW | Store data |
| st_size | output | 2 | Store size code |

## Verification
The stage's internal state shows at the ports as the timing of `in_ready`, `freq_valid` and `st_valid`, and as the contents of the request and store records. A lost or stuck outstanding flag shows up as a missing or repeated fill request. An operand captured wrongly or never cleared shows up in the data of a later store. A reference model running alongside the design predicts every output on every clock, so a wrong state shows up within the cycle after it first affects an output. Directed sequences make the timing and value cases concrete: a register rewritten after capture, responses that arrive too early, and lanes that match at the same time.

// File: rtl/eft_pkg.sv
`timescale 1ns/1ps
package eft_pkg;
    parameter int DW   = 32;
    parameter int AW   = 16;
    parameter int NREG = 8;
    localparam int RW  = $clog2(NREG);

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_MOVE  = 2'd3
    } op_e;

    typedef struct packed {
        op_e            op;
        logic           pred_en;
        logic [RW-1:0]  pred_reg;
        logic           pred_val;
        logic [RW-1:0]  src_a;
        logic [RW-1:0]  src_b;
        logic           dst_en;
        logic [RW-1:0]  dst;
        logic [AW-1:0]  addr;
        logic [1:0]     size;
    } step_t;

    localparam int SW = $bits(step_t);
endpackage

// File: rtl/eft_regfile.sv
`timescale 1ns/1ps
module eft_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ext_we,
    input  logic [$clog2(NREG)-1:0]  ext_idx,
    input  logic [DW-1:0]            ext_data,
    input  logic                     stg_we,
    input  logic [$clog2(NREG)-1:0]  stg_idx,
    input  logic [DW-1:0]            stg_data,
    input  logic [$clog2(NREG)-1:0]  p_idx,
    output logic                     p_vld,
    output logic                     p_bit,
    input  logic [$clog2(NREG)-1:0]  a_idx,
    output logic                     a_vld,
    output logic [DW-1:0]            a_data,
    input  logic [$clog2(NREG)-1:0]  b_idx,
    output logic                     b_vld,
    output logic [DW-1:0]            b_data
);
    typedef struct packed {
        logic [NREG-1:0]         vld;
        logic [NREG-1:0][DW-1:0] val;
    } rf_t;

    rf_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ext_we) begin
            r_d.val[ext_idx] = ext_data;
            r_d.vld[ext_idx] = 1'b1;
        end
        if (stg_we) begin
            r_d.val[stg_idx] = stg_data;
            r_d.vld[stg_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign p_vld  = r_q.vld[p_idx];
    assign p_bit  = r_q.val[p_idx][0];
    assign a_vld  = r_q.vld[a_idx];
    assign a_data = r_q.val[a_idx];
    assign b_vld  = r_q.vld[b_idx];
    assign b_data = r_q.val[b_idx];

    // R12: a port write makes the register usable on the next cycle
    p_ext_sets_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ext_we |=> r_q.vld[$past(ext_idx)]);
endmodule

// File: rtl/eft_fill_match.sv
`timescale 1ns/1ps
module eft_fill_match #(
    parameter int LANES = 4,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic [LANES-1:0]    lane_v,
    input  logic [LANES*AW-1:0] lane_a,
    input  logic [LANES*DW-1:0] lane_d,
    input  logic [AW-1:0]       key,
    output logic                hit,
    output logic [DW-1:0]       hit_data
);
    logic [LANES-1:0] match;

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign match[g] = lane_v[g] && (lane_a[g*AW +: AW] == key);
    end

    // scan from the top so the lowest matching lane is the last to assign
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (match[l]) begin
                hit      = 1'b1;
                hit_data = lane_d[l*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/exec_fill_tracker.sv
`timescale 1ns/1ps
module exec_fill_tracker
    import eft_pkg::*;
#(
    parameter int STEPS = 4,
    parameter int LANES = 4,
    localparam int CW   = $clog2(STEPS + 1),
    localparam int IW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [CW-1:0]         in_count,
    input  logic [STEPS*SW-1:0]   in_steps,
    input  logic                  wr_en,
    input  logic [RW-1:0]         wr_idx,
    input  logic [DW-1:0]         wr_data,
    output logic                  freq_valid,
    output logic [AW-1:0]         freq_addr,
    output logic [1:0]            freq_size,
    input  logic [LANES-1:0]      frsp_valid,
    input  logic [LANES*AW-1:0]   frsp_addr,
    input  logic [LANES*DW-1:0]   frsp_data,
    output logic                  st_valid,
    output logic [AW-1:0]         st_addr,
    output logic [DW-1:0]         st_data,
    output logic [1:0]            st_size
);
    typedef struct packed {
        logic                    busy;
        logic [IW-1:0]           idx;
        logic [CW-1:0]           cnt;
        step_t [STEPS-1:0]       steps;
        logic                    got_a;
        logic                    got_b;
        logic [DW-1:0]           opa;
        logic [DW-1:0]           opb;
        logic                    pend;
        logic                    frv;
        logic [AW-1:0]           fra;
        logic [1:0]              frs;
        logic                    stv;
        logic [AW-1:0]           sta;
        logic [DW-1:0]           std;
        logic [1:0]              sts;
    } state_t;

    state_t s_d, s_q;
    step_t  cur;

    logic          p_vld, p_bit, a_vld, b_vld;
    logic [DW-1:0] a_data, b_data;
    logic          rf_we;
    logic [DW-1:0] rf_wdata;
    logic          hit;
    logic [DW-1:0] hit_data;
    logic          need_a, need_b, a_rdy, b_rdy, adv, skip;
    logic [DW-1:0] op_a, op_b, result;

    assign cur = s_q.steps[s_q.idx];

    eft_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_we   (wr_en),
        .ext_idx  (wr_idx),
        .ext_data (wr_data),
        .stg_we   (rf_we),
        .stg_idx  (cur.dst),
        .stg_data (rf_wdata),
        .p_idx    (cur.pred_reg),
        .p_vld    (p_vld),
        .p_bit    (p_bit),
        .a_idx    (cur.src_a),
        .a_vld    (a_vld),
        .a_data   (a_data),
        .b_idx    (cur.src_b),
        .b_vld    (b_vld),
        .b_data   (b_data)
    );

    eft_fill_match #(.LANES(LANES), .AW(AW), .DW(DW)) u_match (
        .lane_v   (frsp_valid),
        .lane_a   (frsp_addr),
        .lane_d   (frsp_data),
        .key      (cur.addr),
        .hit      (hit),
        .hit_data (hit_data)
    );

    assign need_a = (cur.op != OP_LOAD);
    assign need_b = (cur.op == OP_ADD);
    assign a_rdy  = !need_a || s_q.got_a || a_vld;
    assign b_rdy  = !need_b || s_q.got_b || b_vld;
    assign op_a   = s_q.got_a ? s_q.opa : a_data;
    assign op_b   = s_q.got_b ? s_q.opb : b_data;

    always_comb begin
        case (cur.op)
            OP_ADD:  result = op_a + op_b;
            OP_LOAD: result = hit_data;
            default: result = op_a;
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.frv  = 1'b0;
        s_d.stv  = 1'b0;
        rf_we    = 1'b0;
        rf_wdata = result;
        adv      = 1'b0;
        skip     = 1'b0;
        if (!s_q.busy) begin
            if (in_valid) begin
                s_d.cnt   = (in_count > CW'(STEPS)) ? CW'(STEPS) : in_count;
                s_d.busy  = (in_count != '0);
                s_d.idx   = '0;
                s_d.steps = in_steps;
            end
        end else if (cur.pred_en && !p_vld) begin
            s_d = s_d;  // predicate not yet known: hold
        end else if (cur.pred_en && (p_bit != cur.pred_val)) begin
            skip = 1'b1;
            adv  = 1'b1;
        end else begin
            if (need_a && !s_q.got_a && a_vld) begin
                s_d.got_a = 1'b1;
                s_d.opa   = a_data;
            end
            if (need_b && !s_q.got_b && b_vld) begin
                s_d.got_b = 1'b1;
                s_d.opb   = b_data;
            end
            if (a_rdy && b_rdy) begin
                if (cur.op == OP_LOAD && !s_q.pend) begin
                    s_d.pend = 1'b1;
                    s_d.frv  = 1'b1;
                    s_d.fra  = cur.addr;
                    s_d.frs  = cur.size;
                end else if (cur.op != OP_LOAD || hit) begin
                    rf_we = cur.dst_en;
                    adv   = 1'b1;
                    if (cur.op == OP_STORE) begin
                        s_d.stv = 1'b1;
                        s_d.sta = cur.addr;
                        s_d.std = op_a;
                        s_d.sts = cur.size;
                    end
                end
            end
        end
        if (adv) begin
            s_d.got_a = 1'b0;
            s_d.got_b = 1'b0;
            s_d.opa   = '0;
            s_d.opb   = '0;
            s_d.pend  = 1'b0;
            s_d.idx   = s_q.idx + IW'(1);
            if ((CW'(s_q.idx) + CW'(1)) == s_q.cnt) s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready   = !s_q.busy;
    assign freq_valid = s_q.frv;
    assign freq_addr  = s_q.fra;
    assign freq_size  = s_q.frs;
    assign st_valid   = s_q.stv;
    assign st_addr    = s_q.sta;
    assign st_data    = s_q.std;
    assign st_size    = s_q.sts;

    // R1: a non-empty micro-operation makes the stage busy
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_count != '0) |=> !in_ready);

    // R2: unknown predicate holds the step and produces nothing
    p_pred_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && cur.pred_en && !p_vld) |=> ($stable(s_q.idx) && !st_valid && !freq_valid));

    // R3: a skipped step leaves no trace on the outputs
    p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        skip |=> (!st_valid && !freq_valid));

    // R5: a fill request is a single-cycle pulse
    p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        freq_valid |=> !freq_valid);

    // R7: an unmatched outstanding load keeps the stage on that step
    p_load_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !cur.pred_en && cur.op == OP_LOAD && s_q.pend && !hit)
            |=> ($stable(s_q.idx) && !st_valid));

    // R9: a store record only follows a busy cycle
    p_store_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> $past(s_q.busy));
endmodule

// File: tb/exec_fill_tracker_tb_top.sv
`timescale 1ns/1ps
module exec_fill_tracker_tb_top;
    import eft_pkg::*;

    localparam int ST = 4;
    localparam int LN = 4;
    localparam int CW = $clog2(ST + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [CW-1:0]     in_count = '0;
    logic [ST*SW-1:0]  in_steps = '0;
    logic              wr_en = 1'b0;
    logic [RW-1:0]     wr_idx = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              freq_valid;
    logic [AW-1:0]     freq_addr;
    logic [1:0]        freq_size;
    logic [LN-1:0]     frsp_valid = '0;
    logic [LN*AW-1:0]  frsp_addr = '0;
    logic [LN*DW-1:0]  frsp_data = '0;
    logic              st_valid;
    logic [AW-1:0]     st_addr;
    logic [DW-1:0]     st_data;
    logic [1:0]        st_size;

    exec_fill_tracker #(.STEPS(ST), .LANES(LN)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_count(in_count), .in_steps(in_steps), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .freq_valid(freq_valid), .freq_addr(freq_addr),
        .freq_size(freq_size), .frsp_valid(frsp_valid), .frsp_addr(frsp_addr),
        .frsp_data(frsp_data), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_size(st_size)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [DW-1:0] mv [NREG];
    bit            mvl [NREG];
    bit            mb, mga, mgb, mpend;
    int            mi, mc;
    step_t         ms [ST];
    logic [DW-1:0] moa, mob;
    bit            e_frv, e_stv;
    logic [AW-1:0] e_fra, e_sta;
    logic [1:0]    e_frs, e_sts;
    logic [DW-1:0] e_std;

    always @(posedge clk) begin : model
        step_t st;
        bit adv, dwe, na, nb, found;
        logic [DW-1:0] res;
        if (!rst_n) begin
            mb = 0; mga = 0; mgb = 0; mpend = 0; e_frv = 0; e_stv = 0;
            mi = 0; mc = 0; moa = '0; mob = '0;
            e_fra = '0; e_frs = '0; e_sta = '0; e_std = '0; e_sts = '0;
            for (int k = 0; k < NREG; k++) begin mvl[k] = 0; mv[k] = '0; end
        end else begin
            e_frv = 0; e_stv = 0; adv = 0; dwe = 0; res = '0;
            st = ms[0];
            if (!mb) begin
                if (in_valid) begin
                    mc = (int'(in_count) > ST) ? ST : int'(in_count);
                    mb = (mc != 0);
                    mi = 0;
                    for (int k = 0; k < ST; k++) ms[k] = in_steps[k*SW +: SW];
                end
            end else begin
                st = ms[mi];
                if (st.pred_en && !mvl[st.pred_reg]) begin
                    adv = 0;
                end else if (st.pred_en && (mv[st.pred_reg][0] != st.pred_val)) begin
                    adv = 1;
                end else begin
                    na = (st.op != OP_LOAD);
                    nb = (st.op == OP_ADD);
                    if (na && !mga && mvl[st.src_a]) begin mga = 1; moa = mv[st.src_a]; end
                    if (nb && !mgb && mvl[st.src_b]) begin mgb = 1; mob = mv[st.src_b]; end
                    if ((!na || mga) && (!nb || mgb)) begin
                        if (st.op == OP_LOAD) begin
                            if (!mpend) begin
                                mpend = 1; e_frv = 1; e_fra = st.addr; e_frs = st.size;
                            end else begin
                                found = 0;
                                for (int l = 0; l < LN; l++)
                                    if (!found && frsp_valid[l] && frsp_addr[l*AW +: AW] == st.addr) begin
                                        found = 1; res = frsp_data[l*DW +: DW];
                                    end
                                if (found) begin adv = 1; dwe = st.dst_en; end
                            end
                        end else begin
                            res = (st.op == OP_ADD) ? moa + mob : moa;
                            dwe = st.dst_en; adv = 1;
                            if (st.op == OP_STORE) begin
                                e_stv = 1; e_sta = st.addr; e_std = moa; e_sts = st.size;
                            end
                        end
                    end
                end
                if (adv) begin
                    mga = 0; mgb = 0; mpend = 0; moa = '0; mob = '0;
                    mi++;
                    if (mi == mc) mb = 0;
                end
            end
            if (wr_en) begin mv[wr_idx] = wr_data; mvl[wr_idx] = 1; end
            if (dwe) begin mv[st.dst] = res; mvl[st.dst] = 1; end
        end
    end

    // ---------------- per-cycle comparison and collection ----------------
    typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } rec_t;
    rec_t stq[$];
    int   nreq = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(in_ready == !mb, "R1 in_ready vs model", 64'(in_ready), 64'(!mb));
            chk(freq_valid == e_frv && (!e_frv || (freq_addr == e_fra && freq_size == e_frs)),
                "R5 fill request vs model", {45'd0, freq_valid, freq_size, freq_addr},
                {45'd0, e_frv, e_frs, e_fra});
            chk(st_valid == e_stv && (!e_stv || (st_addr == e_sta && st_data == e_std && st_size == e_sts)),
                "R9 store record vs model", {13'd0, st_valid, st_size, st_addr, st_data},
                {13'd0, e_stv, e_sts, e_sta, e_std});
            if (st_valid) stq.push_back('{st_addr, st_data});
            if (freq_valid) nreq++;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog expired actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic step_t mk(op_e op, int a, int b, bit de, int d, int addr, int sz,
                                 bit pe = 0, int pr = 0, bit pv = 0);
        step_t s;
        s.op = op; s.pred_en = pe; s.pred_reg = RW'(pr); s.pred_val = pv;
        s.src_a = RW'(a); s.src_b = RW'(b); s.dst_en = de; s.dst = RW'(d);
        s.addr = AW'(addr); s.size = 2'(sz);
        return s;
    endfunction

    task automatic load_uop(input int n, input step_t s0, s1, s2, s3);
        in_count = CW'(n);
        in_steps[0*SW +: SW] = s0;
        in_steps[1*SW +: SW] = s1;
        in_steps[2*SW +: SW] = s2;
        in_steps[3*SW +: SW] = s3;
    endtask

    task automatic send(input int n, input step_t s0, s1, s2, s3);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        load_uop(n, s0, s1, s2, s3);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr(input int idx, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = RW'(idx); wr_data = DW'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lane(input int l, input int a, input int d);
        frsp_valid[l] = 1'b1;
        frsp_addr[l*AW +: AW] = AW'(a);
        frsp_data[l*DW +: DW] = DW'(d);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_req();
        @(negedge clk);
        while (!freq_valid) @(negedge clk);
    endtask

    step_t z;

    initial begin
        z = mk(OP_MOVE, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(in_ready && !freq_valid && !st_valid, "R11 reset idle",
            {61'd0, in_ready, freq_valid, st_valid}, 64'h4);

        // R12 + R9: register writes, add then store
        wr(1, 5); wr(2, 7);
        stq.delete();
        send(2, mk(OP_ADD, 1, 2, 1, 3, 0, 0), mk(OP_STORE, 3, 0, 0, 0, 'h100, 2), z, z);
        wait_idle();
        chk(stq.size() == 1, "R9 one store", stq.size(), 1);
        if (stq.size() == 1) chk(stq[0].a == 'h100 && stq[0].d == 12, "R12 add of written regs",
                                 {stq[0].a, stq[0].d}, {16'h100, 32'd12});

        // R3: predicate mismatch skips the step
        wr(4, 0);
        stq.delete();
        send(2, mk(OP_STORE, 1, 0, 0, 0, 'h200, 2, 1, 4, 1),
                mk(OP_STORE, 1, 0, 0, 0, 'h204, 2, 1, 4, 0), z, z);
        wait_idle();
        chk(stq.size() == 1, "R3 skipped store absent", stq.size(), 1);
        if (stq.size() == 1) chk(stq[0].a == 'h204 && stq[0].d == 5, "R3 taken store",
                                 {stq[0].a, stq[0].d}, {16'h204, 32'd5});

        // R2: unknown predicate stalls
        stq.delete();
        send(1, mk(OP_STORE, 1, 0, 0, 0, 'h300, 1, 1, 5, 1), z, z, z);
        repeat (6) @(negedge clk);
        chk(stq.size() == 0 && !in_ready, "R2 stalled on predicate", {stq.size(), in_ready}, 0);
        wr(5, 1);
        wait_idle();
        chk(stq.size() == 1 && stq[0].a == 'h300, "R2 released store", stq.size(), 1);

        // R4: captured operand survives a later rewrite
        stq.delete();
        send(2, mk(OP_ADD, 1, 6, 1, 7, 0, 0), mk(OP_STORE, 7, 0, 0, 0, 'h400, 2), z, z);
        repeat (3) @(negedge clk);
        wr(1, 100);
        repeat (2) @(negedge clk);
        chk(stq.size() == 0 && !in_ready, "R4 stalled on source", stq.size(), 0);
        wr(6, 1);
        wait_idle();
        chk(stq.size() == 1 && stq[0].d == 6, "R4 kept operand",
            stq.size() == 1 ? stq[0].d : 32'hdead, 6);

        // R5 R6 R7 R10: two loads to the same address
        stq.delete(); nreq = 0;
        send(4, mk(OP_LOAD, 0, 0, 1, 2, 'h500, 1), mk(OP_STORE, 2, 0, 0, 0, 'h504, 2),
                mk(OP_LOAD, 0, 0, 1, 3, 'h500, 1), mk(OP_STORE, 3, 0, 0, 0, 'h508, 2));
        wait_req();
        chk(freq_addr == 'h500 && freq_size == 1, "R5 request fields",
            {freq_size, freq_addr}, {2'd1, 16'h500});
        lane(0, 'h999, 'h77);
        @(negedge clk);
        frsp_valid = '0;
        lane(1, 'h500, 'hAAAA); lane(2, 'h500, 'hBBBB);
        chk(stq.size() == 0 && !st_valid, "R7 no match stalls", stq.size(), 0);
        @(negedge clk);
        frsp_valid = '0;
        wait_req();
        lane(3, 'h500, 'h1234);
        @(negedge clk);
        frsp_valid = '0;
        wait_idle();
        chk(nreq == 2, "R10 fresh request for second load", nreq, 2);
        chk(stq.size() == 2, "R6 both loads completed", stq.size(), 2);
        if (stq.size() == 2) begin
            chk(stq[0].d == 'hAAAA, "R6 lowest lane wins", stq[0].d, 'hAAAA);
            chk(stq[1].d == 'h1234, "R10 second load data", stq[1].d, 'h1234);
        end

        // R8: response before the request is outstanding is dropped
        stq.delete(); nreq = 0;
        send(2, mk(OP_LOAD, 0, 0, 1, 4, 'h600, 2), mk(OP_STORE, 4, 0, 0, 0, 'h604, 2), z, z);
        lane(0, 'h600, 'h11);
        @(negedge clk);
        frsp_valid = '0;
        chk(freq_valid == 1'b1, "R8 request after early response", freq_valid, 1);
        repeat (3) @(negedge clk);
        chk(!in_ready && stq.size() == 0, "R8 early response discarded", stq.size(), 0);
        lane(0, 'h600, 'h22);
        @(negedge clk);
        frsp_valid = '0;
        wait_idle();
        chk(stq.size() == 1 && stq[0].d == 'h22, "R8 later response used",
            stq.size() == 1 ? stq[0].d : 32'hdead, 'h22);
        chk(nreq == 1, "R5 single request per load", nreq, 1);

        // R12: empty micro-operation
        send(0, z, z, z, z);
        chk(in_ready == 1'b1, "R12 empty uop leaves idle", in_ready, 1);

        // R1: offers while busy are ignored
        stq.delete();
        send(1, mk(OP_STORE, 1, 0, 0, 0, 'h700, 2, 1, 0, 1), z, z, z);
        load_uop(1, mk(OP_STORE, 1, 0, 0, 0, 'h704, 2), z, z, z);
        in_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk(!in_ready, "R1 busy refuses input", in_ready, 0);
        in_valid = 1'b0;
        wr(0, 0);
        wait_idle();
        chk(stq.size() == 0, "R1 offer while busy not taken", stq.size(), 0);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule